// File: doc/BRIEF.md
# Configurable Logic Cell Storage Element

This block is one storage cell of a programmable logic array. A static configuration word sets how the cell behaves. The cell takes a single data input, which is the sum-of-products result computed elsewhere. The configuration picks one of three behaviours: a D register, a T (toggle) register, or a plain combinational pass-through.

In the two register behaviours, the configuration also picks the clock. It can be one of two global clocks, with a chosen capture edge, or one of two clocks made from local control terms. Local control terms can preset or clear the register asynchronously, and a global active-low reset always clears it.

The cell value drives a pad through a tri-state enable. That enable comes from one of four local control terms, or is tied on or off. A global 3-state input overrides the enable. Two feedback taps are provided: one taken before the pad buffer and one taken after it. A cell built without a pad keeps only the first tap.

Top module: `mc_cell`

## Requirements
- R1: Mode field cfg[9:8]=00 selects D mode: on each capture edge of the selected clock, mc_fb takes the value of d.
- R2: Mode field cfg[9:8]=01 selects T mode: on each capture edge, mc_fb inverts when d is 1 and holds when d is 0.
- R3: Mode field cfg[9:8]=10 or 11 selects combinational mode: mc_fb and pad_o follow d with no register, and clock edges have no effect.
- R4: Clock field cfg[7:6] picks the register clock: 00 gclk0, 01 gclk1, 10 ct[6], 11 ct[7]. Edges on the sources that are not selected cause no capture.
- R5: Edge bit cfg[5]: 0 captures on the rising edge and 1 on the falling edge of a selected global clock. Control-term clocks always capture on their rising edge.
- R6: Field cfg[4:3] sets the asynchronous control: 00 none, 01 preset from ct[0], 10 clear from ct[1], 11 is treated as clear only. A control term that is not enabled has no effect.
- R7: While grst_n is low the register is 0 at once, whatever the preset or clear setting. The register therefore starts at 0 after reset.
- R8: Field cfg[2:0] sets the pad enable: 0 to 3 follow ct[2] to ct[5] in that order, 4 is always on, and 5 to 7 are always off.
- R9: While gts is high, pad_oe is 0 whatever the enable setting.
- R10: pin_fb equals pad_o while pad_oe is 1, and equals pad_i while pad_oe is 0.
- R11: With HAS_PIN=0, pad_o, pad_oe and pin_fb are held at 0, and mc_fb behaves as in a cell with a pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk0 | input | 1 | Global clock 0 |
| gclk1 | input | 1 | Global clock 1 |
| grst_n | input | 1 | Global asynchronous reset, active low |
| gts | input | 1 | Global 3-state, active high |
| cfg | input | 10 | Static configuration word |
| ct | input | 8 | Local control terms |
| d | input | 1 | Sum-of-products data input |
| pad_i | input | 1 | Value seen on the pad from outside |
| pad_o | output | 1 | Value driven toward the pad |
| pad_oe | output | 1 | Pad driver enable |
| mc_fb | output | 1 | Feedback taken before the pad buffer |
| pin_fb | output | 1 | Feedback taken after the pad buffer |

## Verification
The register path is swept over both register modes, all four clock sources and both edge settings. It uses a data pattern with repeated ones and zeros, so D capture can be told apart from T toggling. The value is sampled between the rising and the falling half of each pulse, which shows which edge did the capture. The same sampling also shows that pulses on the sources that are not selected change nothing.

Each asynchronous setting is driven with both control terms, starting from a register value where an ignored term would be visible. The enable selector is swept over all eight codes, all sixteen patterns of the four enable terms, and both gts levels. The pad input is driven opposite to the cell value, so the two feedback taps differ whenever the enable is off.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int NUM_CT   = 8;
  localparam int CT_PRE   = 0;
  localparam int CT_CLR   = 1;
  localparam int CT_OE0   = 2;
  localparam int NUM_OE   = 4;
  localparam int CT_CLKA  = 6;
  localparam int CT_CLKB  = 7;

  typedef enum logic [1:0] {MODE_D = 2'd0, MODE_T = 2'd1, MODE_COMB = 2'd2, MODE_COMB2 = 2'd3} mode_e;
  typedef enum logic [1:0] {CK_G0 = 2'd0, CK_G1 = 2'd1, CK_LA = 2'd2, CK_LB = 2'd3} clk_e;
  typedef enum logic [1:0] {AR_OFF = 2'd0, AR_SET = 2'd1, AR_CLR = 2'd2, AR_BOTH = 2'd3} ar_e;
  typedef enum logic [2:0] {OE_T0 = 3'd0, OE_T1 = 3'd1, OE_T2 = 3'd2, OE_T3 = 3'd3,
                            OE_ON = 3'd4, OE_OFF = 3'd5, OE_OFF6 = 3'd6, OE_OFF7 = 3'd7} oe_e;

  typedef struct packed {
    mode_e mode;
    clk_e  clk;
    logic  fall;
    ar_e   ar;
    oe_e   oe;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/mc_clk_sel.sv
module mc_clk_sel
  import mc_pkg::*;
(
  input  logic       gclk0,
  input  logic       gclk1,
  input  logic [1:0] ct_clk,
  input  clk_e       src,
  input  logic       fall,
  output logic       rclk
);
  always_comb begin
    case (src)
      CK_G0:   rclk = gclk0 ^ fall;
      CK_G1:   rclk = gclk1 ^ fall;
      CK_LA:   rclk = ct_clk[0];
      default: rclk = ct_clk[1];
    endcase
  end
endmodule

// File: rtl/mc_arc.sv
module mc_arc
  import mc_pkg::*;
(
  input  logic [1:0] ct_ar,
  input  ar_e        sel,
  output logic       aset,
  output logic       aclr
);
  always_comb begin
    aset = 1'b0;
    aclr = 1'b0;
    case (sel)
      AR_SET:          aset = ct_ar[0];
      AR_CLR, AR_BOTH: aclr = ct_ar[1];
      default: ;
    endcase
  end
endmodule

// File: rtl/mc_store.sv
module mc_store
  import mc_pkg::*;
(
  input  logic  rclk,
  input  logic  grst_n,
  input  logic  aset,
  input  logic  aclr,
  input  mode_e mode,
  input  logic  d,
  output logic  mc_val
);
  logic q;
  logic is_reg;

  assign is_reg = (mode == MODE_D) || (mode == MODE_T);

  always_ff @(posedge rclk or negedge grst_n or posedge aset or posedge aclr) begin
    if (!grst_n)              q <= 1'b0;
    else if (aclr)            q <= 1'b0;
    else if (aset)            q <= 1'b1;
    else if (mode == MODE_T)  q <= q ^ d;
    else                      q <= d;
  end

  assign mc_val = is_reg ? q : d;

  AST_PRESET_HOLD: assert property (@(posedge rclk) disable iff (!grst_n)
    (aset && !aclr) |-> q); // R6
  AST_CLEAR_HOLD: assert property (@(posedge rclk) disable iff (!grst_n)
    aclr |-> !q); // R6
endmodule

// File: rtl/mc_oe_sel.sv
module mc_oe_sel
  import mc_pkg::*;
#(
  parameter int N_TERMS = NUM_OE
) (
  input  logic [N_TERMS-1:0] ct_oe,
  input  oe_e                sel,
  input  logic               gts,
  output logic               oe
);
  logic local_en;

  always_comb begin
    if (int'(sel) < N_TERMS) local_en = ct_oe[sel[$clog2(N_TERMS)-1:0]];
    else                     local_en = (sel == OE_ON);
  end

  assign oe = local_en & ~gts;
endmodule

// File: rtl/mc_cell.sv
module mc_cell
  import mc_pkg::*;
#(
  parameter bit HAS_PIN = 1'b1
) (
  input  logic             gclk0,
  input  logic             gclk1,
  input  logic             grst_n,
  input  logic             gts,
  input  logic [CFG_W-1:0] cfg,
  input  logic [NUM_CT-1:0] ct,
  input  logic             d,
  input  logic             pad_i,
  output logic             pad_o,
  output logic             pad_oe,
  output logic             mc_fb,
  output logic             pin_fb
);
  cfg_t c;
  logic rclk;
  logic aset;
  logic aclr;
  logic mc_val;
  logic oe_int;

  assign c = cfg_t'(cfg);

  mc_clk_sel u_clk (
    .gclk0  (gclk0),
    .gclk1  (gclk1),
    .ct_clk ({ct[CT_CLKB], ct[CT_CLKA]}),
    .src    (c.clk),
    .fall   (c.fall),
    .rclk   (rclk)
  );

  mc_arc u_arc (
    .ct_ar ({ct[CT_CLR], ct[CT_PRE]}),
    .sel   (c.ar),
    .aset  (aset),
    .aclr  (aclr)
  );

  mc_store u_store (
    .rclk   (rclk),
    .grst_n (grst_n),
    .aset   (aset),
    .aclr   (aclr),
    .mode   (c.mode),
    .d      (d),
    .mc_val (mc_val)
  );

  mc_oe_sel #(.N_TERMS(NUM_OE)) u_oe (
    .ct_oe (ct[CT_OE0 +: NUM_OE]),
    .sel   (c.oe),
    .gts   (gts),
    .oe    (oe_int)
  );

  assign mc_fb = mc_val;

  generate
    if (HAS_PIN) begin : g_pin
      assign pad_o  = mc_val;
      assign pad_oe = oe_int;
      assign pin_fb = oe_int ? mc_val : pad_i;
    end else begin : g_buried
      assign pad_o  = 1'b0;
      assign pad_oe = 1'b0;
      assign pin_fb = 1'b0;
    end
  endgenerate

  AST_GTS_HIZ: assert property (@(posedge rclk) disable iff (!grst_n)
    gts |-> !pad_oe); // R9
  AST_PIN_FB: assert property (@(posedge rclk) disable iff (!grst_n)
    pad_oe |-> (pin_fb == pad_o)); // R10
  AST_COMB_PASS: assert property (@(posedge rclk) disable iff (!grst_n)
    (c.mode == MODE_COMB || c.mode == MODE_COMB2) |-> (mc_fb == d)); // R3
  AST_AR_EXCL: assert property (@(posedge rclk) disable iff (!grst_n)
    $onehot0({aset, aclr})); // R6
endmodule

// File: tb/mc_cell_tb_top.sv
module mc_cell_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       gclk0 = 0, gclk1 = 0, grst_n = 0, gts = 0, d = 0, pad_i = 0;
  logic [9:0] cfg = '0;
  logic [7:0] ct = '0;
  logic pad_o, pad_oe, mc_fb, pin_fb;
  logic b_pad_o, b_pad_oe, b_mc_fb, b_pin_fb;
  int total = 0, bad = 0;

  mc_cell #(.HAS_PIN(1'b1)) dut_i (
    .gclk0(gclk0), .gclk1(gclk1), .grst_n(grst_n), .gts(gts), .cfg(cfg), .ct(ct),
    .d(d), .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe), .mc_fb(mc_fb), .pin_fb(pin_fb));

  mc_cell #(.HAS_PIN(1'b0)) dut_b (
    .gclk0(gclk0), .gclk1(gclk1), .grst_n(grst_n), .gts(gts), .cfg(cfg), .ct(ct),
    .d(d), .pad_i(pad_i), .pad_o(b_pad_o), .pad_oe(b_pad_oe), .mc_fb(b_mc_fb), .pin_fb(b_pin_fb));

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] mk(int m, int c, int f, int a, int o);
    return {2'(m), 2'(c), 1'(f), 2'(a), 3'(o)};
  endfunction

  task automatic reset_to(logic [9:0] c);
    grst_n = 0; ct = '0; gclk0 = 0; gclk1 = 0; gts = 0;
    #2 cfg = c;
    #2 grst_n = 1;
    #2;
  endtask

  task automatic drive_src(int s, logic v);
    case (s)
      0: gclk0 = v;
      1: gclk1 = v;
      2: ct[6] = v;
      default: ct[7] = v;
    endcase
  endtask

  task automatic pulse_g0(logic dv);
    d = dv; #1 gclk0 = 1; #2 gclk0 = 0; #1;
  endtask

  task automatic pulse_ct(int i);
    ct[i] = 1; #2 ct[i] = 0; #2;
  endtask

  initial begin
    logic expq, nxt, dv, rise_cap, expoe;
    #3;
    chk("R7 power-on", mc_fb, 1'b0);
    // register sweep: mode x source x edge
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        for (int f = 0; f < 2; f++) begin
          reset_to(mk(m, s, f, 0, 4));
          expq = 0;
          chk("R7 after reset", mc_fb, expq);
          for (int k = 0; k < 6; k++) begin
            dv = 1'((k * 5) >> 1);
            d = dv; #2;
            for (int o = 0; o < 4; o++)
              if (o != s) begin drive_src(o, 1); #1 drive_src(o, 0); #1; end
            chk("R4 unselected source", mc_fb, expq);
            nxt = (m == 0) ? dv : (expq ^ dv);
            rise_cap = (s >= 2) || (f == 0);
            drive_src(s, 1); #2;
            if (rise_cap) expq = nxt;
            chk("R5 after rise", mc_fb, expq);
            drive_src(s, 0); #2;
            if (!rise_cap) expq = nxt;
            if (m == 0) chk("R1 D capture", mc_fb, expq);
            else        chk("R2 T toggle", mc_fb, expq);
            chk("R11 buried mc_fb", b_mc_fb, expq);
          end
        end
    // combinational mode
    for (int m = 2; m < 4; m++) begin
      reset_to(mk(m, 0, 0, 0, 4));
      for (int k = 0; k < 4; k++) begin
        d = 1'(k); #1;
        chk("R3 pass", mc_fb, d);
        chk("R3 pad_o", pad_o, d);
        gclk0 = 1; #1 gclk0 = 0; #1;
        chk("R3 clock ignored", mc_fb, d);
      end
    end
    // preset only
    reset_to(mk(0, 0, 0, 1, 4));
    pulse_ct(0); chk("R6 preset", mc_fb, 1'b1);
    pulse_ct(1); chk("R6 clear ignored", mc_fb, 1'b1);
    ct[0] = 1; #1 grst_n = 0; #2;
    chk("R7 reset over preset", mc_fb, 1'b0);
    ct[0] = 0; #1 grst_n = 1; #2;
    chk("R7 held after release", mc_fb, 1'b0);
    // clear only
    reset_to(mk(0, 0, 0, 2, 4));
    pulse_g0(1); chk("R1 D capture", mc_fb, 1'b1);
    pulse_ct(1); chk("R6 clear", mc_fb, 1'b0);
    pulse_ct(0); chk("R6 preset ignored", mc_fb, 1'b0);
    // both selected -> clear only
    reset_to(mk(0, 0, 0, 3, 4));
    pulse_g0(1);
    pulse_ct(1); chk("R6 both: clear", mc_fb, 1'b0);
    pulse_ct(0); chk("R6 both: preset ignored", mc_fb, 1'b0);
    // none
    reset_to(mk(0, 0, 0, 0, 4));
    pulse_g0(1);
    pulse_ct(1); chk("R6 off: clear ignored", mc_fb, 1'b1);
    pulse_g0(0);
    pulse_ct(0); chk("R6 off: preset ignored", mc_fb, 1'b0);
    // enable selector sweep
    for (int sel = 0; sel < 8; sel++) begin
      reset_to(mk(0, 0, 0, 0, sel));
      pulse_g0(1'(sel));
      for (int c = 0; c < 16; c++)
        for (int g = 0; g < 2; g++) begin
          ct[5:2] = 4'(c); gts = 1'(g); pad_i = ~1'(sel); #1;
          expoe = (sel < 4) ? 1'((c >> sel) & 1) : (sel == 4);
          if (g == 1) expoe = 0;
          if (g == 1) chk("R9 gts", pad_oe, expoe);
          else        chk("R8 enable", pad_oe, expoe);
          chk("R10 pin_fb", pin_fb, expoe ? 1'(sel) : ~1'(sel));
          chk("R11 buried pad_oe", b_pad_oe, 1'b0);
          chk("R11 buried pin_fb", b_pin_fb, 1'b0);
          chk("R11 buried pad_o", b_pad_o, 1'b0);
        end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule